// File: doc/BRIEF.md
# Delayed Transmit Interrupt Controller

This block turns transmit descriptor write-back events into the transmit write-back interrupt. Each write-back arrives as a one-cycle strobe with two flags: a report-status flag, which asks for completion reporting, and a delay flag, which asks for the interrupt to be postponed. A programmable delay value is held in a local register. A delayed write-back loads that value into a countdown counter. The interrupt is raised when the countdown runs out. A write-back that asks for status without delay raises the interrupt at once and cancels any countdown in progress.

The countdown advances only on a unit-tick input, so the time base comes from outside the block. An interrupt enable level gates every raise. An expiry or immediate event seen while the enable is clear is dropped, not held. The block acts only on the interrupt. The status write-back path never waits on it.

Control is a three-state machine. `ST_IDLE` has no countdown pending. `ST_ARMED` has a countdown running. `ST_FIRE` lasts one cycle and drives the interrupt pulse. The transitions are:
- *arm*: any state to `ST_ARMED` on a delayed write-back.
- *reload*: `ST_ARMED` to itself on a further delayed write-back.
- *count*: `ST_ARMED` to itself on a tick that leaves the counter above zero.
- *expire*: `ST_ARMED` to `ST_FIRE` or `ST_IDLE` on the tick that brings the counter to zero.
- *bypass*: any state to `ST_FIRE` or `ST_IDLE` on a non-delayed write-back.
- *retire*: `ST_FIRE` to `ST_IDLE` when nothing else happens.

For *expire* and *bypass*, the target is `ST_FIRE` when the enable is set and `ST_IDLE` when it is clear.

Top module: `txint_delay_ctrl`

## Requirements
- R1: After reset, `irq_pulse` is 0, no countdown is pending, and the delay value register holds `DELAY_RESET`. An asserted reset cancels a running countdown.
- R2: A write-back with `wb_rs`=1 and `wb_ide`=1 loads the counter from the delay register, and `irq_pulse` stays 0 in the cycle that follows. For a delay D≥1, the pulse appears in the cycle after the D-th tick.
- R3: Each further delayed write-back reloads the counter from the delay register, even while a countdown is running.
- R4: A write-back with `wb_rs`=1 and `wb_ide`=0, with the enable set, drives `irq_pulse` high in the cycle after the write-back and cancels any pending countdown.
- R5: A write-back with `wb_rs`=0 has no effect on the counter or the interrupt.
- R6: If the countdown expires while `wb_int_en`=0, no pulse is raised and the event is dropped.
- R7: A delay value of 0 loaded by a delayed write-back raises the pulse after the first tick that follows.
- R8: The counter moves only on cycles with `tick`=1. Without ticks, a pending countdown never expires.
- R9: Every qualifying event gives exactly one pulse cycle. Back-to-back immediate events give back-to-back pulses.
- R10: A write-back in the same cycle as a tick takes precedence and the tick is discarded. A write to the delay register applies only to write-backs in later cycles.
- R11: A non-delayed write-back while `wb_int_en`=0 raises no pulse and still cancels the pending countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| delay_we | input | 1 | Write strobe for the delay value register |
| delay_wdata | input | DELAY_W | New delay value, in ticks |
| wb_valid | input | 1 | One-cycle descriptor write-back strobe |
| wb_rs | input | 1 | Write-back requests status reporting |
| wb_ide | input | 1 | Write-back requests a delayed interrupt |
| wb_int_en | input | 1 | Write-back interrupt enable level |
| tick | input | 1 | Unit time step for the countdown |
| irq_pulse | output | 1 | Transmit write-back interrupt cause, one cycle per event |

## Verification
The bench builds the block with `DELAY_W` = 8 and `DELAY_RESET` = 0. The reset value of 0 puts the zero-delay case in reach straight after reset, with no register write. Delays of 1 to 3 ticks keep the reload, cancel and same-cycle precedence cases within a few cycles each. Together they reach every transition of the state machine.

// File: rtl/txid_pkg.sv
package txid_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } txid_state_e;

endpackage

// File: rtl/txid_delay_reg.sv
module txid_delay_reg #(
    parameter int unsigned DELAY_W     = 16,
    parameter int unsigned DELAY_RESET = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [DELAY_W-1:0] wdata,
    output logic [DELAY_W-1:0] value
);

    localparam logic [DELAY_W-1:0] RST_VAL = DELAY_W'(DELAY_RESET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= RST_VAL;
        end else if (we) begin
            value <= wdata;
        end
    end

endmodule

// File: rtl/txid_countdown.sv
module txid_countdown #(
    parameter int unsigned DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DELAY_W-1:0] load_val,
    input  logic               clear,
    input  logic               dec,
    output logic               last
);

    localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

    logic [DELAY_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (clear) begin
            count <= '0;
        end else if (dec && (count != '0)) begin
            count <= count - ONE;
        end
    end

    // the next decrement lands on (or already sits at) zero
    assign last = (count <= ONE);

endmodule

// File: rtl/txid_fsm.sv
module txid_fsm
    import txid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_delayed,
    input  logic ev_immediate,
    input  logic tick,
    input  logic int_en,
    input  logic cnt_last,
    output logic cnt_load,
    output logic cnt_clear,
    output logic cnt_dec,
    output logic irq
);

    txid_state_e state_q, state_d;
    logic        expire;

    assign expire = (state_q == ST_ARMED) && tick && cnt_last
                    && !ev_delayed && !ev_immediate;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FIRE: begin
                if (ev_delayed) begin
                    state_d = ST_ARMED;
                end else if (ev_immediate) begin
                    state_d = int_en ? ST_FIRE : ST_IDLE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ARMED: begin
                if (ev_delayed) begin
                    state_d = ST_ARMED;
                end else if (ev_immediate || expire) begin
                    state_d = int_en ? ST_FIRE : ST_IDLE;
                end else begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cnt_load  = ev_delayed;
        cnt_clear = ev_immediate || expire;
        cnt_dec   = (state_q == ST_ARMED) && tick && !ev_delayed && !ev_immediate;
        irq       = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/txint_delay_ctrl.sv
module txint_delay_ctrl #(
    parameter int unsigned DELAY_W     = 16,
    parameter int unsigned DELAY_RESET = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               delay_we,
    input  logic [DELAY_W-1:0] delay_wdata,
    input  logic               wb_valid,
    input  logic               wb_rs,
    input  logic               wb_ide,
    input  logic               wb_int_en,
    input  logic               tick,
    output logic               irq_pulse
);

    logic [DELAY_W-1:0] delay_val;
    logic               ev_delayed;
    logic               ev_immediate;
    logic               cnt_load;
    logic               cnt_clear;
    logic               cnt_dec;
    logic               cnt_last;

    assign ev_delayed   = wb_valid && wb_rs && wb_ide;
    assign ev_immediate = wb_valid && wb_rs && !wb_ide;

    txid_delay_reg #(
        .DELAY_W    (DELAY_W),
        .DELAY_RESET(DELAY_RESET)
    ) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (delay_we),
        .wdata(delay_wdata),
        .value(delay_val)
    );

    txid_countdown #(
        .DELAY_W(DELAY_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(delay_val),
        .clear   (cnt_clear),
        .dec     (cnt_dec),
        .last    (cnt_last)
    );

    txid_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_delayed  (ev_delayed),
        .ev_immediate(ev_immediate),
        .tick        (tick),
        .int_en      (wb_int_en),
        .cnt_last    (cnt_last),
        .cnt_load    (cnt_load),
        .cnt_clear   (cnt_clear),
        .cnt_dec     (cnt_dec),
        .irq         (irq_pulse)
    );

endmodule

// File: rtl/txid_checker.sv
module txid_checker (
    input logic clk,
    input logic rst_n,
    input logic wb_valid,
    input logic wb_rs,
    input logic wb_ide,
    input logic wb_int_en,
    input logic tick,
    input logic irq_pulse
);

    // R2: a delayed write-back never raises the pulse in the next cycle
    a_r2_delayed_not_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_rs && wb_ide) |=> !irq_pulse);

    // R4 / R9: enabled non-delayed write-back gives a pulse next cycle
    a_r4_immediate_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_rs && !wb_ide && wb_int_en) |=> irq_pulse);

    // R11: disabled non-delayed write-back gives no pulse
    a_r11_immediate_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_rs && !wb_ide && !wb_int_en) |=> !irq_pulse);

    // R6: nothing fires from a cycle in which the enable is clear
    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_int_en |=> !irq_pulse);

    // R5: a write-back without status, on a cycle without tick, raises nothing
    a_r5_no_rs_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_rs && !tick) |=> !irq_pulse);

    // R8: a pulse needs a tick or an immediate write-back one cycle before
    a_r8_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pulse) |-> $past(tick || (wb_valid && wb_rs && !wb_ide)));

endmodule

bind txint_delay_ctrl txid_checker u_txid_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_valid (wb_valid),
    .wb_rs    (wb_rs),
    .wb_ide   (wb_ide),
    .wb_int_en(wb_int_en),
    .tick     (tick),
    .irq_pulse(irq_pulse)
);

// File: tb/test_txint_delay_ctrl.sv
`timescale 1ns/1ps
module test_txint_delay_ctrl;

    localparam int unsigned DW = 8;
    localparam int unsigned NV = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          delay_we = 1'b0;
    logic [DW-1:0] delay_wdata = '0;
    logic          wb_valid = 1'b0;
    logic          wb_rs = 1'b0;
    logic          wb_ide = 1'b0;
    logic          wb_int_en = 1'b1;
    logic          tick = 1'b0;
    logic          irq_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    txint_delay_ctrl #(.DELAY_W(DW), .DELAY_RESET(0)) i_txint_delay_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .delay_we   (delay_we),
        .delay_wdata(delay_wdata),
        .wb_valid   (wb_valid),
        .wb_rs      (wb_rs),
        .wb_ide     (wb_ide),
        .wb_int_en  (wb_int_en),
        .tick       (tick),
        .irq_pulse  (irq_pulse)
    );

    // vector: {we, data[7:0], valid, rs, ide, en, tick, exp_irq, req[3:0]}
    function automatic logic [18:0] vc(input logic we, input logic [7:0] d,
                                       input logic vl, input logic rs, input logic ide,
                                       input logic en, input logic tk, input logic ex,
                                       input logic [3:0] rq);
        return {we, d, vl, rs, ide, en, tk, ex, rq};
    endfunction

    localparam logic [18:0] VEC [NV] = '{
        // R2: delay 3, countdown
        vc(1,3, 0,0,0,1,0, 0, 2), vc(0,0, 1,1,1,1,0, 0, 2), vc(0,0, 0,0,0,1,1, 0, 2),
        vc(0,0, 0,0,0,1,0, 0, 8), vc(0,0, 0,0,0,1,1, 0, 2), vc(0,0, 0,0,0,1,1, 1, 2),
        vc(0,0, 0,0,0,1,0, 0, 9), vc(0,0, 0,0,0,1,1, 0, 8),
        // R3: reload mid-count
        vc(0,0, 1,1,1,1,0, 0, 3), vc(0,0, 0,0,0,1,1, 0, 3), vc(0,0, 0,0,0,1,1, 0, 3),
        vc(0,0, 1,1,1,1,0, 0, 3), vc(0,0, 0,0,0,1,1, 0, 3), vc(0,0, 0,0,0,1,1, 0, 3),
        vc(0,0, 0,0,0,1,1, 1, 3), vc(0,0, 0,0,0,1,0, 0, 9),
        // R4: immediate cancels pending count
        vc(0,0, 1,1,1,1,0, 0, 4), vc(0,0, 0,0,0,1,1, 0, 4), vc(0,0, 1,1,0,1,0, 1, 4),
        vc(0,0, 0,0,0,1,1, 0, 4), vc(0,0, 0,0,0,1,1, 0, 4), vc(0,0, 0,0,0,1,1, 0, 4),
        vc(0,0, 0,0,0,1,1, 0, 4),
        // R5: write-backs without status ignored
        vc(0,0, 1,1,1,1,0, 0, 5), vc(0,0, 1,0,1,1,1, 0, 5), vc(0,0, 1,0,0,1,0, 0, 5),
        vc(0,0, 0,0,0,1,1, 0, 5), vc(0,0, 0,0,0,1,1, 1, 5),
        // R6: expiry while disabled dropped
        vc(0,0, 1,1,1,1,0, 0, 6), vc(0,0, 0,0,0,1,1, 0, 6), vc(0,0, 0,0,0,1,1, 0, 6),
        vc(0,0, 0,0,0,0,1, 0, 6), vc(0,0, 0,0,0,1,1, 0, 6), vc(0,0, 0,0,0,1,1, 0, 6),
        // R10: write-back beats a same-cycle tick
        vc(0,0, 1,1,1,1,0, 0,10), vc(0,0, 0,0,0,1,1, 0,10), vc(0,0, 0,0,0,1,1, 0,10),
        vc(0,0, 1,1,1,1,1, 0,10), vc(0,0, 0,0,0,1,1, 0,10), vc(0,0, 0,0,0,1,1, 0,10),
        vc(0,0, 0,0,0,1,1, 1,10),
        // R10: register write seen only by later write-backs
        vc(1,1, 1,1,1,1,0, 0,10), vc(0,0, 0,0,0,1,1, 0,10), vc(0,0, 0,0,0,1,1, 0,10),
        vc(0,0, 0,0,0,1,1, 1,10), vc(0,0, 1,1,1,1,0, 0,10), vc(0,0, 0,0,0,1,1, 1,10),
        // R7: zero delay
        vc(1,0, 0,0,0,1,0, 0, 7), vc(0,0, 1,1,1,1,0, 0, 7), vc(0,0, 0,0,0,1,0, 0, 7),
        vc(0,0, 0,0,0,1,1, 1, 7),
        // R11: disabled immediate still cancels
        vc(1,2, 0,0,0,1,0, 0,11), vc(0,0, 1,1,1,1,0, 0,11), vc(0,0, 1,1,0,0,0, 0,11),
        vc(0,0, 0,0,0,1,1, 0,11), vc(0,0, 0,0,0,1,1, 0,11), vc(0,0, 0,0,0,1,1, 0,11),
        // R9: back-to-back immediate pulses
        vc(0,0, 1,1,0,1,0, 1, 9), vc(0,0, 1,1,0,1,0, 1, 9), vc(0,0, 0,0,0,1,0, 0, 9)
    };

    task automatic check(input logic act, input logic exp, input int rq, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: irq_pulse=%0b expected %0b", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [DW-1:0] d, input logic vl,
                         input logic rs, input logic ide, input logic en, input logic tk);
        delay_we = we; delay_wdata = d; wb_valid = vl; wb_rs = rs;
        wb_ide = ide; wb_int_en = en; tick = tk;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog: run=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(irq_pulse, 1'b0, 1, "during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(irq_pulse, 1'b0, 1, "after reset");

        // R1 / R7: reset delay value is 0, fires on first tick
        drive(0, 0, 1, 1, 1, 1, 0); @(negedge clk);
        check(irq_pulse, 1'b0, 1, "load reset delay");
        drive(0, 0, 0, 0, 0, 1, 1); @(negedge clk);
        check(irq_pulse, 1'b1, 7, "reset delay expiry");
        drive(0, 0, 0, 0, 0, 1, 0); @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            v = VEC[i];
            drive(v[18], v[17:10], v[9], v[8], v[7], v[6], v[5]);
            @(negedge clk);
            check(irq_pulse, v[4], int'(v[3:0]), $sformatf("vector %0d", i));
        end
        drive(0, 0, 0, 0, 0, 1, 0);

        // R8: armed countdown without ticks never expires
        drive(1, 1, 0, 0, 0, 1, 0); @(negedge clk);
        drive(0, 0, 1, 1, 1, 1, 0); @(negedge clk);
        drive(0, 0, 0, 0, 0, 1, 0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(irq_pulse, 1'b0, 8, "no tick hold");
        end
        drive(0, 0, 0, 0, 0, 1, 1); @(negedge clk);
        check(irq_pulse, 1'b1, 8, "tick after hold");
        drive(0, 0, 0, 0, 0, 1, 0); @(negedge clk);
        check(irq_pulse, 1'b0, 9, "single pulse");

        // R1: reset cancels a running countdown and restores the delay value
        drive(1, 5, 0, 0, 0, 1, 0); @(negedge clk);
        drive(0, 0, 1, 1, 1, 1, 0); @(negedge clk);
        drive(0, 0, 0, 0, 0, 1, 0);
        rst_n = 1'b0; @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 1, 1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(irq_pulse, 1'b0, 1, "reset cancels count");
        end
        drive(0, 0, 1, 1, 1, 1, 0); @(negedge clk);
        drive(0, 0, 0, 0, 0, 1, 1); @(negedge clk);
        check(irq_pulse, 1'b1, 1, "delay back to reset value");
        drive(0, 0, 0, 0, 0, 1, 0); @(negedge clk);

        finish_run();
    end

endmodule